// File: doc/BRIEF.md
# Segment Register Load Validator

This block decides whether a 16-bit selector may enter one of six segment registers. A load request carries the selector, the target register and the current privilege level. The block splits the selector into table index, table choice and requested privilege. It fetches the 8-byte descriptor over a 32-bit memory port. It then runs the null, bounds, type, privilege and present checks that apply to that target. The result is either a commit or a fault with a vector and an error code.

On commit, the selector and the decoded base, limit, access byte and flag nibble are written into the target register's hidden cache. That cache is readable through a registered read port. It is not refreshed from memory until the register is loaded again. Only one load is handled at a time: a request is accepted when the block is idle, and it is answered by exactly one done pulse.

Target encoding on `req_seg` and `rd_seg`: 0 = CS, 1 = SS, 2 = DS, 3 = ES, 4 = FS, 5 = GS. Codes 6 and 7 are not registers.

Top module: `seg_load_check`

## Requirements
- R1: After reset, `done` and `mem_req` are low, and every cache entry reads back as all zeros.
- R2: A request whose target is CS (code 0) or an unused code (6, 7) ends with a fault of vector 6 and error code 0. It performs no memory read and changes no cache entry.
- R3: A selector with bits 15..2 all zero is null.
  - A null load into DS, ES, FS or GS commits with no memory read. The cache holds the selector as given, with zero base, limit, access and flags.
  - A null load into SS faults with vector 13 and error code 0.
- R4: Selector bit 2 picks the local table (1) or the global table (0), each with its own base and limit input. The descriptor offset is the selector with bits 2..0 cleared. If offset+7 exceeds the table limit, the load faults with vector 13 and no memory read. With limit 47, index 5 passes and indexes 6 and 7 fail.
- R5: A non-null, in-bounds load reads exactly two 32-bit words.
  - The first read is at table base + offset and the second at that address + 4.
  - Each read holds `mem_req` and its address until `mem_ready` is seen.
  - Descriptor layout:
    - word0 = {base[15:0], limit[15:0]}
    - word1 = {base[31:24], flags[3:0], limit[19:16], access[7:0], base[23:16]}
- R6: For DS, ES, FS and GS, the descriptor must have access bit 4 set and must be either data (access bit 3 clear) or readable code (bits 3 and 1 set). Otherwise the load faults with vector 13.
- R7: For DS, ES, FS and GS, the load faults with vector 13 unless max(CPL, RPL) is at most the DPL. DPL is access bits 6..5 and RPL is selector bits 1..0.
- R8: For SS, the load faults with vector 13 unless all of these hold:
  - access bit 4 is set, bit 3 is clear and bit 1 is set (writable data);
  - RPL equals CPL;
  - DPL equals CPL.
- R9: The present bit (access bit 7) is checked only after the type and privilege checks pass. When it is clear, the load faults with vector 11 for DS, ES, FS and GS, or vector 12 for SS.
- R10: For faults raised against a descriptor or the bounds, the error code is the selector with bits 1..0 forced to 0: index in bits 15..3, table bit in bit 2, and zeros in bits 1 and 0.
- R11: A commit writes the selector, base, limit, access and flags into the target's cache entry, visible on the read port one cycle after `rd_seg` is applied. A faulting load leaves every entry unchanged.
- R12: A cache entry keeps its values when the descriptor in memory changes later. It takes the new values only when the register is reloaded.
- R13: Each accepted request produces exactly one single-cycle `done` pulse. `commit` is high only together with `done`, and `fault_vec` is meaningful when `done` is high and `commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request, taken when idle |
| req_sel | input | 16 | Selector to load |
| req_seg | input | 3 | Target register code |
| req_cpl | input | 2 | Current privilege level |
| gtab_base | input | ADDR_W | Global table base address |
| gtab_limit | input | TLIM_W | Global table limit (last valid byte) |
| ltab_base | input | ADDR_W | Local table base address |
| ltab_limit | input | TLIM_W | Local table limit (last valid byte) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_ready | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-load pulse |
| commit | output | 1 | Load succeeded (with done) |
| fault_vec | output | 8 | Fault vector (6, 11, 12 or 13) |
| fault_code | output | 16 | Fault error code |
| rd_seg | input | 3 | Cache entry to read back |
| rd_sel | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_access | output | 8 | Cached access byte |
| rd_flags | output | 4 | Cached flag nibble |

## Verification
Selectors are aimed at a small global and local table holding the following descriptors:
- ring-0 and ring-3 data;
- readable code and execute-only code;
- a system descriptor;
- read-only data;
- two entries with the present bit clear.

Each target class is tried against these entries, so the run tells apart the data-register rules (the max of CPL and RPL, readable code allowed) from the stack rules (exact privilege equality, writable data only). Bounds cases sit on both sides of a table limit, and they also confirm that a rejected load never touches the memory port, as the number of reads per load is compared. Not-present descriptors are paired with privilege failures to show the check order. Cache readback after commits, faults and later memory edits shows that only a successful reload changes an entry.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam logic [2:0] SEG_CS = 3'd0;
  localparam logic [2:0] SEG_SS = 3'd1;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_SF = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RD0, ST_RD1, ST_EVAL
  } ld_state_e;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] limit;
    logic [7:0]  access;
    logic [3:0]  flags;
  } shadow_t;

  function automatic shadow_t unpack_desc(input logic [15:0] s,
                                          input logic [31:0] w0,
                                          input logic [31:0] w1);
    shadow_t r;
    r.sel    = s;
    r.base   = {w1[31:24], w1[7:0], w0[31:16]};
    r.limit  = {w1[19:16], w0[15:0]};
    r.access = w1[15:8];
    r.flags  = w1[23:20];
    return r;
  endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic [15:0]       sel,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [TLIM_W-1:0] glim,
  input  logic [ADDR_W-1:0] lbase,
  input  logic [TLIM_W-1:0] llim,
  output logic              is_null,
  output logic              in_bounds,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int CW = ((TLIM_W > 16) ? TLIM_W : 16) + 1;

  logic [15:0]       offset;
  logic [TLIM_W-1:0] lim;
  logic [ADDR_W-1:0] base;

  always_comb begin
    offset    = {sel[15:3], 3'b000};
    lim       = sel[2] ? llim  : glim;
    base      = sel[2] ? lbase : gbase;
    is_null   = (sel[15:2] == 14'd0);
    in_bounds = (CW'(offset) + CW'(7)) <= CW'(lim);
    desc_addr = base + ADDR_W'(offset);
  end
endmodule

// File: rtl/seg_desc_judge.sv
module seg_desc_judge
  import seg_pkg::*;
(
  input  logic [7:0] access,
  input  logic [2:0] target,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  output logic       pass,
  output logic [7:0] vec
);
  logic [1:0] dpl, eff;
  logic       is_seg, is_exec, rw_bit, present, stack, rules_ok;

  always_comb begin
    dpl     = access[6:5];
    is_seg  = access[4];
    is_exec = access[3];
    rw_bit  = access[1];
    present = access[7];
    stack   = (target == SEG_SS);
    eff     = (cpl > rpl) ? cpl : rpl;
    if (stack)
      rules_ok = is_seg && !is_exec && rw_bit && (rpl == cpl) && (dpl == cpl);
    else
      rules_ok = is_seg && (!is_exec || rw_bit) && (eff <= dpl);
    pass = 1'b0;
    if (!rules_ok)     vec = VEC_GP;
    else if (!present) vec = stack ? VEC_SF : VEC_NP;
    else begin
      vec  = 8'd0;
      pass = 1'b1;
    end
  end
endmodule

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
  import seg_pkg::*;
#(
  parameter int NSEG = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  shadow_t    wr_data,
  input  logic [2:0] rd_idx,
  output shadow_t    rd_data
);
  shadow_t ents [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                              ents[g] <= '0;
      else if (wr_en && int'(wr_idx) == g)  ents[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= '0;
    else if (int'(rd_idx) < NSEG) rd_data <= ents[rd_idx];
    else                         rd_data <= '0;
  end

  assert_no_cs_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != SEG_CS && int'(wr_idx) < NSEG));
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16,
  parameter int NSEG   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [15:0]       req_sel,
  input  logic [2:0]        req_seg,
  input  logic [1:0]        req_cpl,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              commit,
  output logic [7:0]        fault_vec,
  output logic [15:0]       fault_code,
  input  logic [2:0]        rd_seg,
  output logic [15:0]       rd_sel,
  output logic [31:0]       rd_base,
  output logic [19:0]       rd_limit,
  output logic [7:0]        rd_access,
  output logic [3:0]        rd_flags
);
  ld_state_e         st;
  logic [15:0]       r_sel;
  logic [2:0]        r_seg;
  logic [1:0]        r_cpl;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       w0, w1;

  logic              is_null, in_bounds, pass, bad_tgt, null_ok;
  logic [ADDR_W-1:0] desc_addr;
  logic [7:0]        jvec;
  logic [15:0]       sel_code;
  logic              wr_en;
  shadow_t           wr_data, rd_data;

  seg_sel_decode #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_dec (
    .sel(r_sel), .gbase(gtab_base), .glim(gtab_limit),
    .lbase(ltab_base), .llim(ltab_limit),
    .is_null(is_null), .in_bounds(in_bounds), .desc_addr(desc_addr)
  );

  seg_desc_judge u_judge (
    .access(w1[15:8]), .target(r_seg), .cpl(r_cpl), .rpl(r_sel[1:0]),
    .pass(pass), .vec(jvec)
  );

  always_comb begin
    bad_tgt  = (r_seg == SEG_CS) || (int'(r_seg) >= NSEG);
    null_ok  = (st == ST_CHK) && !bad_tgt && is_null && (r_seg != SEG_SS);
    sel_code = {r_sel[15:2], 2'b00};
    wr_en    = null_ok || ((st == ST_EVAL) && pass);
    if (null_ok) begin
      wr_data     = '0;
      wr_data.sel = r_sel;
    end else begin
      wr_data = unpack_desc(r_sel, w0, w1);
    end
    mem_req  = (st == ST_RD0) || (st == ST_RD1);
    mem_addr = r_addr;
  end

  seg_shadow_file #(.NSEG(NSEG)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(r_seg), .wr_data(wr_data),
    .rd_idx(rd_seg), .rd_data(rd_data)
  );

  always_comb begin
    rd_sel    = rd_data.sel;
    rd_base   = rd_data.base;
    rd_limit  = rd_data.limit;
    rd_access = rd_data.access;
    rd_flags  = rd_data.flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      r_sel      <= '0;
      r_seg      <= '0;
      r_cpl      <= '0;
      r_addr     <= '0;
      w0         <= '0;
      w1         <= '0;
      done       <= 1'b0;
      commit     <= 1'b0;
      fault_vec  <= '0;
      fault_code <= '0;
    end else begin
      done   <= 1'b0;
      commit <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          r_sel <= req_sel;
          r_seg <= req_seg;
          r_cpl <= req_cpl;
          st    <= ST_CHK;
        end
        ST_CHK: begin
          if (bad_tgt) begin
            done <= 1'b1; fault_vec <= VEC_UD; fault_code <= '0; st <= ST_IDLE;
          end else if (is_null) begin
            done <= 1'b1; st <= ST_IDLE;
            if (r_seg == SEG_SS) begin
              fault_vec <= VEC_GP; fault_code <= '0;
            end else begin
              commit <= 1'b1; fault_vec <= '0; fault_code <= '0;
            end
          end else if (!in_bounds) begin
            done <= 1'b1; fault_vec <= VEC_GP; fault_code <= sel_code; st <= ST_IDLE;
          end else begin
            r_addr <= desc_addr;
            st     <= ST_RD0;
          end
        end
        ST_RD0: if (mem_ready) begin
          w0     <= mem_rdata;
          r_addr <= r_addr + ADDR_W'(4);
          st     <= ST_RD1;
        end
        ST_RD1: if (mem_ready) begin
          w1 <= mem_rdata;
          st <= ST_EVAL;
        end
        ST_EVAL: begin
          done <= 1'b1;
          st   <= ST_IDLE;
          if (pass) begin
            commit <= 1'b1; fault_vec <= '0; fault_code <= '0;
          end else begin
            fault_vec <= jvec; fault_code <= sel_code;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_single_done_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_commit_with_done_R13: assert property (@(posedge clk) disable iff (rst)
    commit |-> done);
  assert_hold_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  assert_known_vector_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !commit) |-> (fault_vec == VEC_UD || fault_vec == VEC_NP ||
                           fault_vec == VEC_SF || fault_vec == VEC_GP));
  assert_code_low_bits_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault_code[1:0] == 2'b00));
endmodule

// File: tb/tb_seg_load_check.sv
module tb_seg_load_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [2:0]  req_seg = '0;
  logic [1:0]  req_cpl = '0;
  logic [31:0] gtab_base = 32'h0000_0000;
  logic [15:0] gtab_limit = 16'd47;
  logic [31:0] ltab_base = 32'h0000_0080;
  logic [15:0] ltab_limit = 16'd31;
  logic        mem_req, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, commit;
  logic [7:0]  fault_vec;
  logic [15:0] fault_code;
  logic [2:0]  rd_seg = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base;
  logic [19:0] rd_limit;
  logic [7:0]  rd_access;
  logic [3:0]  rd_flags;

  always #5 clk = ~clk;

  seg_load_check dut (.*);

  typedef struct {
    bit          c;
    logic [7:0]  v;
    logic [15:0] code;
    int          reads;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0, n_bad = 0, rd_cnt = 0, cycles = 0;
  bit    got_done = 0, tgl = 0;
  logic [31:0] mem [64];

  function automatic logic [31:0] dbase(int t, int i);
    return {4'(t + 1), 4'(i), 24'h5A3C10};
  endfunction
  function automatic logic [19:0] dlim(int t, int i);
    return {4'(i), 12'h0F0, 4'(t)};
  endfunction

  task automatic put_desc(int t, int i, logic [31:0] b, logic [19:0] l, logic [7:0] a);
    int w = (t == 0) ? 2 * i : 32 + 2 * i;
    mem[w]     = {b[15:0], l[15:0]};
    mem[w + 1] = {b[31:24], 4'hC, l[19:16], a, b[23:16]};
  endtask

  // memory responder: ready on alternate cycles, counts handshakes
  always @(negedge clk) begin
    tgl = ~tgl;
    mem_ready = mem_req && tgl;
    mem_rdata = mem[mem_addr[7:2]];
    if (mem_ready) rd_cnt++;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    cycles++;
    if (!rst && done) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R13 unexpected done: actual done=1 expected no pulse");
      end else begin
        e = sb.pop_front();
        if (commit !== e.c || (!e.c && (fault_vec !== e.v || fault_code !== e.code)) ||
            rd_cnt != e.reads) begin
          n_bad++;
          $display("FAIL %s: actual c=%0d v=%0d code=%h reads=%0d expected c=%0d v=%0d code=%h reads=%0d",
                   e.tag, commit, fault_vec, fault_code, rd_cnt, e.c, e.v, e.code, e.reads);
        end
      end
      got_done = 1;
    end
  end

  task automatic load(logic [15:0] s, logic [2:0] g, logic [1:0] c, bit ec,
                      logic [7:0] ev, logic [15:0] ecode, int er, string tag);
    exp_t e;
    e.c = ec; e.v = ev; e.code = ecode; e.reads = er; e.tag = tag;
    @(negedge clk); #1;
    sb.push_back(e);
    rd_cnt = 0; got_done = 0;
    req_sel = s; req_seg = g; req_cpl = c; req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    while (!got_done) begin @(negedge clk); #1; end
  endtask

  task automatic readback(logic [2:0] g, logic [15:0] es, logic [31:0] eb,
                          logic [19:0] el, logic [7:0] ea, logic [3:0] ef, string tag);
    @(negedge clk); #1;
    rd_seg = g;
    @(negedge clk); #1;
    n_chk++;
    if (rd_sel !== es || rd_base !== eb || rd_limit !== el || rd_access !== ea || rd_flags !== ef) begin
      n_bad++;
      $display("FAIL %s cache[%0d]: actual %h/%h/%h/%h/%h expected %h/%h/%h/%h/%h", tag, g,
               rd_sel, rd_base, rd_limit, rd_access, rd_flags, es, eb, el, ea, ef);
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    put_desc(0, 1, dbase(0, 1), dlim(0, 1), 8'h9A);
    put_desc(0, 2, dbase(0, 2), dlim(0, 2), 8'h92);
    put_desc(0, 3, dbase(0, 3), dlim(0, 3), 8'hFA);
    put_desc(0, 4, dbase(0, 4), dlim(0, 4), 8'hF2);
    put_desc(0, 5, dbase(0, 5), dlim(0, 5), 8'h72);
    put_desc(1, 0, dbase(1, 0), dlim(1, 0), 8'hF0);
    put_desc(1, 1, dbase(1, 1), dlim(1, 1), 8'hF8);
    put_desc(1, 2, dbase(1, 2), dlim(1, 2), 8'hE9);
    put_desc(1, 3, dbase(1, 3), dlim(1, 3), 8'h12);
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (done !== 1'b0 || mem_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: actual done=%b mem_req=%b expected 0/0", done, mem_req);
    end
    readback(3'd1, 16'h0, 32'h0, 20'h0, 8'h0, 4'h0, "R1");

    load(16'h0010, 3'd0, 2'd0, 0, 8'd6, 16'h0, 0, "R2 CS target");
    load(16'h0010, 3'd7, 2'd0, 0, 8'd6, 16'h0, 0, "R2 unused target");
    load(16'h0003, 3'd2, 2'd3, 1, 8'd0, 16'h0, 0, "R3 null into DS");
    readback(3'd2, 16'h0003, 32'h0, 20'h0, 8'h0, 4'h0, "R3");
    load(16'h0001, 3'd1, 2'd1, 0, 8'd13, 16'h0, 0, "R3 null into SS");

    load(16'h0010, 3'd2, 2'd0, 1, 8'd0, 16'h0, 2, "R5 DS ring0 data");
    readback(3'd2, 16'h0010, dbase(0, 2), dlim(0, 2), 8'h92, 4'hC, "R11");
    load(16'h0010, 3'd3, 2'd3, 0, 8'd13, 16'h0010, 2, "R7 CPL3 vs DPL0");
    readback(3'd3, 16'h0, 32'h0, 20'h0, 8'h0, 4'h0, "R11 fault leaves ES");
    load(16'h0012, 3'd2, 2'd0, 0, 8'd13, 16'h0010, 2, "R7 RPL2 vs DPL0 R10");
    readback(3'd2, 16'h0010, dbase(0, 2), dlim(0, 2), 8'h92, 4'hC, "R11 fault leaves DS");
    load(16'h0023, 3'd4, 2'd3, 1, 8'd0, 16'h0, 2, "R7 ring3 data");

    load(16'h0038, 3'd2, 2'd0, 0, 8'd13, 16'h0038, 0, "R4 index7 limit47");
    load(16'h0030, 3'd2, 2'd0, 0, 8'd13, 16'h0030, 0, "R4 index6 limit47");
    load(16'h002B, 3'd2, 2'd3, 0, 8'd11, 16'h0028, 2, "R4 index5 passes bounds R9");
    load(16'h0027, 3'd5, 2'd3, 0, 8'd13, 16'h0024, 0, "R4 local limit31");

    load(16'h0010, 3'd1, 2'd0, 1, 8'd0, 16'h0, 2, "R8 SS ring0");
    load(16'h0013, 3'd1, 2'd3, 0, 8'd13, 16'h0010, 2, "R8 DPL mismatch");
    load(16'h0023, 3'd1, 2'd0, 0, 8'd13, 16'h0020, 2, "R8 RPL mismatch");
    load(16'h001B, 3'd1, 2'd3, 0, 8'd13, 16'h0018, 2, "R8 code into SS");
    load(16'h0007, 3'd1, 2'd3, 0, 8'd13, 16'h0004, 2, "R8 read-only into SS R10");
    load(16'h002B, 3'd1, 2'd3, 0, 8'd12, 16'h0028, 2, "R9 SS not present");

    load(16'h001B, 3'd3, 2'd3, 1, 8'd0, 16'h0, 2, "R6 readable code into ES");
    load(16'h000F, 3'd4, 2'd3, 0, 8'd13, 16'h000C, 2, "R6 execute-only code");
    load(16'h0017, 3'd5, 2'd3, 0, 8'd13, 16'h0014, 2, "R6 system descriptor");
    load(16'h0007, 3'd5, 2'd3, 1, 8'd0, 16'h0, 2, "R5 local table");
    readback(3'd5, 16'h0007, dbase(1, 0), dlim(1, 0), 8'hF0, 4'hC, "R5");

    load(16'h001F, 3'd2, 2'd3, 0, 8'd13, 16'h001C, 2, "R9 privilege before present");
    load(16'h001C, 3'd2, 2'd0, 0, 8'd11, 16'h001C, 2, "R9 not present");

    put_desc(0, 2, 32'hCAFE_0000, 20'h0_1234, 8'h93);
    readback(3'd2, 16'h0010, dbase(0, 2), dlim(0, 2), 8'h92, 4'hC, "R12 stale kept");
    load(16'h0010, 3'd2, 2'd0, 1, 8'd0, 16'h0, 2, "R12 reload");
    readback(3'd2, 16'h0010, 32'hCAFE_0000, 20'h0_1234, 8'h93, 4'hC, "R12 reloaded");

    repeat (4) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R13 missing done: actual %0d pending expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule